// File: doc/BRIEF.md
# Sequenced-Feed Watchdog Timer

This peripheral watches for a stalled processor. It sits on a simple register bus that has an address, a write strobe, write data and combinational read data. Four registers are mapped on that bus: a control word, a reload value, a write-only key port and a read-only view of the live count. The watchdog clock is divided by a fixed factor of four, and each divided tick lowers a 24-bit counter by one. Software keeps the system alive by writing a two-word key, 0xAA and then 0x55, to the key port. Each correct key reloads the counter from the reload value.

The counter starts only after two steps. Software first sets the run bit, and then writes a correct key. From that point the block is armed, and the run bit and the reset-permit bit can no longer be cleared. While armed, the block raises a one-cycle reset request in two cases, but only if the reset-permit bit is set. The first case is the counter expiring. The second is a key sequence that goes wrong: a second word other than 0x55, or a write to any other register between the two key words. An expiry while resets are permitted also sets a sticky flag that software clears.

Top module: `seq_watchdog`

## Requirements
- R1: After reset the control word reads 0, the reload value reads 0xFF, the live count reads 0xFF and `rst_req` is low.
- R2: The reload value is register 0x04 and holds the low 24 bits of the write data. A value below 0xFF is stored as 0xFF.
- R3: A correct key is a full-word write of 0xAA to register 0x08 followed by a full-word write of 0x55 to register 0x08, with no write to another address in between. Idle cycles between the two writes are allowed. It loads the counter from the reload value at the edge that takes the 0x55, whether or not the block is armed, and it restarts the divide-by-4 phase.
- R4: While armed, the counter falls by one on every fourth clock edge after a correct key. While not armed, it holds its value.
- R5: The block becomes armed only through a correct key that completes while control bit 0 (run) is already 1. A correct key with run at 0 does not arm it.
- R6: Control word at 0x00 has bit 0 run, bit 1 reset permit and bit 2 expiry flag. Before arming, bits 0 and 1 take the written value. Once armed, writing 0 to bit 0 or bit 1 is ignored.
- R7: While armed, a tick taken with the count at 0 reloads the reload value. If reset is permitted, `rst_req` is high for exactly the one cycle after edge 4*(reload+1) counted from the key edge.
- R8: While armed with reset permitted, a write to 0x08 after 0xAA of anything other than 0x55 (0xAA included) raises `rst_req` in the cycle after that write.
- R9: While armed with reset permitted, a write to another address after 0xAA aborts the key and raises `rst_req` in the cycle after that write. The aborting write still takes effect.
- R10: The expiry flag (bit 2) is set by an expiry with reset permitted. Writing 0 to bit 2 clears it, and writing 1 does not set it. An expiry without reset permission leaves it at 0.
- R11: `rst_req` never rises while the block is not armed or while reset permission is 0.
- R12: Register 0x0C reads the live count. The key port 0x08 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions check on every cycle the properties that never depend on the stimulus:
- arming is permanent and only a correct key with run set can cause it;
- the run and reset-permit bits stay set while armed;
- the count holds while not armed and steps down by exactly one on an armed tick;
- the reload value never drops below its floor;
- every reset request is gated by armed and reset permission and comes from an expiry or a bad key;
- the flag rises only on a permitted expiry.

Only the bench scenarios can show the exact cycle of the expiry request, the reload after count zero, and that a bad second word or an aborting write raises the request at once. The same holds for clamping, the full-word key comparison and the readback values.

// File: rtl/seq_wdt_pkg.sv
package seq_wdt_pkg;

  typedef enum logic {
    FS_IDLE   = 1'b0,
    FS_PRIMED = 1'b1
  } feed_state_t;

  localparam int unsigned OFS_CTRL   = 'h0;
  localparam int unsigned OFS_RELOAD = 'h4;
  localparam int unsigned OFS_KEY    = 'h8;
  localparam int unsigned OFS_COUNT  = 'hC;

  localparam int unsigned KEY_FIRST  = 'hAA;
  localparam int unsigned KEY_SECOND = 'h55;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_PERM  = 1;
  localparam int unsigned CB_FLAG  = 2;
  localparam int unsigned CTRL_W   = 3;

endpackage

// File: rtl/seq_wdt_prescaler.sv
module seq_wdt_prescaler #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(PRESCALE - 1);

  logic [DIV_W-1:0] phase_q;

  function automatic logic [DIV_W-1:0] next_phase(input logic [DIV_W-1:0] p);
    return (p == LAST) ? '0 : p + DIV_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= next_phase(phase_q);
  end

  assign tick = (phase_q == LAST);
endmodule

// File: rtl/seq_wdt_feed_seq.sv
module seq_wdt_feed_seq
  import seq_wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic              wr_other,
  input  logic [DATA_W-1:0] wdata,
  output logic              feed_ok,
  output logic              feed_bad
);
  feed_state_t st_q, st_d;

  function automatic logic is_word(input logic [DATA_W-1:0] d, input int unsigned k);
    return d == DATA_W'(k);
  endfunction

  always_comb begin
    st_d     = st_q;
    feed_ok  = 1'b0;
    feed_bad = 1'b0;
    unique case (st_q)
      FS_IDLE: begin
        if (wr_key && is_word(wdata, KEY_FIRST)) st_d = FS_PRIMED;
      end
      FS_PRIMED: begin
        if (wr_key) begin
          feed_ok  = is_word(wdata, KEY_SECOND);
          feed_bad = !is_word(wdata, KEY_SECOND);
          st_d     = FS_IDLE;
        end else if (wr_other) begin
          feed_bad = 1'b1;
          st_d     = FS_IDLE;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/seq_wdt_downcount.sv
module seq_wdt_downcount #(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned INIT_VAL = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] step(
    input logic [CNT_W-1:0] c, input logic ld, input logic ex,
    input logic adv, input logic [CNT_W-1:0] rv);
    if (ld || ex) return rv;
    if (adv)      return c - CNT_W'(1);
    return c;
  endfunction

  assign expire = run && tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(INIT_VAL);
    else        cnt_q <= step(cnt_q, load, expire, run && tick, load_val);
  end

  assign count = cnt_q;
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import seq_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned TC_FLOOR = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(TC_FLOOR);

  logic sel_ctrl, sel_reload, sel_key, sel_count;
  logic wr_ctrl, wr_reload, wr_key, wr_other;
  logic run_q, perm_q, flag_q, armed;
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W-1:0] count;
  logic tick, feed_ok, feed_bad, expire;
  logic rst_req_q;

  assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
  assign sel_key    = (bus_addr == ADDR_W'(OFS_KEY));
  assign sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));

  assign wr_ctrl   = bus_we && sel_ctrl;
  assign wr_reload = bus_we && sel_reload;
  assign wr_key    = bus_we && sel_key;
  assign wr_other  = bus_we && !sel_key;

  function automatic logic [CNT_W-1:0] clamp_reload(input logic [DATA_W-1:0] d);
    logic [CNT_W-1:0] v;
    v = d[CNT_W-1:0];
    return (v < FLOOR_V) ? FLOOR_V : v;
  endfunction

  function automatic logic lock_bit(input logic locked, input logic cur, input logic wr);
    return locked ? (cur | wr) : wr;
  endfunction

  seq_wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(feed_ok), .tick(tick)
  );

  seq_wdt_feed_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_key(wr_key), .wr_other(wr_other),
    .wdata(bus_wdata), .feed_ok(feed_ok), .feed_bad(feed_bad)
  );

  seq_wdt_downcount #(.CNT_W(CNT_W), .INIT_VAL(TC_FLOOR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(armed), .tick(tick), .load(feed_ok),
    .load_val(tc_q), .count(count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      perm_q <= 1'b0;
      armed  <= 1'b0;
      tc_q   <= FLOOR_V;
    end else begin
      if (wr_ctrl) begin
        run_q  <= lock_bit(armed, run_q,  bus_wdata[CB_RUN]);
        perm_q <= lock_bit(armed, perm_q, bus_wdata[CB_PERM]);
      end
      if (wr_reload) tc_q <= clamp_reload(bus_wdata);
      if (feed_ok && run_q) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag_q <= 1'b0;
    else if (expire && perm_q)         flag_q <= 1'b1;
    else if (wr_ctrl && !bus_wdata[CB_FLAG]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= armed && perm_q && (expire || feed_bad);
  end
  assign rst_req = rst_req_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)   bus_rdata = DATA_W'({flag_q, perm_q, run_q});
    if (sel_reload) bus_rdata = DATA_W'(tc_q);
    if (sel_count)  bus_rdata = DATA_W'(count);
  end
endmodule

// File: rtl/seq_watchdog_chk.sv
module seq_watchdog_chk #(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned TC_FLOOR = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             run_q,
  input logic             perm_q,
  input logic             flag_q,
  input logic             tick,
  input logic             expire,
  input logic             feed_ok,
  input logic             feed_bad,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] tc_q,
  input logic             rst_req
);
  assert_armed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  assert_arm_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(feed_ok && run_q));
  assert_run_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && run_q) |=> run_q);
  assert_perm_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && perm_q) |=> perm_q);
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !feed_ok) |=> $stable(count));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !feed_ok && count != '0) |=> (count == $past(count) - CNT_W'(1)));
  assert_reload_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q >= CNT_W'(TC_FLOOR));
  assert_req_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(armed && perm_q));
  assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(expire || feed_bad));
  assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire && perm_q));
endmodule

bind seq_watchdog seq_watchdog_chk #(.CNT_W(CNT_W), .TC_FLOOR(TC_FLOOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .run_q(run_q), .perm_q(perm_q),
  .flag_q(flag_q), .tick(tick), .expire(expire), .feed_ok(feed_ok),
  .feed_bad(feed_bad), .count(count), .tc_q(tc_q), .rst_req(rst_req)
);

// File: tb/seq_watchdog_bench.sv
module seq_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seq_watchdog u_seq_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    apply_reset();
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rd(4'h0, v); check("R1 control", v, 32'h0);
    rd(4'h4, v); check("R1 reload", v, 32'hFF);
    rd(4'hC, v); check("R1/R12 count", v, 32'hFF);
    rd(4'h8, v); check("R12 key port reads 0", v, 32'h0);
    rd(4'h2, v); check("R12 unmapped reads 0", v, 32'h0);
  endtask

  task automatic t_reload_clamp();
    logic [31:0] v;
    apply_reset();
    wr(4'h4, 32'h10);       rd(4'h4, v); check("R2 clamp low", v, 32'hFF);
    wr(4'h4, 32'h12345678); rd(4'h4, v); check("R2 truncate", v, 32'h345678);
    wr(4'h4, 32'hFE);       rd(4'h4, v); check("R2 clamp FE", v, 32'hFF);
    wr(4'h4, 32'h100);      rd(4'h4, v); check("R2 above floor", v, 32'h100);
  endtask

  task automatic t_unarmed();
    logic [31:0] v;
    apply_reset();
    wr(4'h4, 32'h300);
    feed();
    rd(4'hC, v); check("R3 load without arm", v, 32'h300);
    repeat (40) @(negedge clk);
    rd(4'hC, v); check("R4/R5 holds unarmed", v, 32'h300);
    wr(4'h0, 32'h3);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h11);
    check("R11 no request unarmed", {31'b0, rst_req}, 32'h0);
    wr(4'h0, 32'h0);
    rd(4'h0, v); check("R6 clear before arm", v, 32'h0);
    wr(4'h0, 32'h1);
    feed();
    wr(4'h0, 32'h0);
    rd(4'h0, v); check("R6 run locked", v, 32'h1);
    repeat (8) @(negedge clk);
    rd(4'hC, v); check("R5/R4 armed counts", v, 32'h2FE);
  endtask

  task automatic t_expiry();
    logic [31:0] v;
    int bad_at;
    localparam int M = 4 * (32'h100 + 1);
    apply_reset();
    wr(4'h4, 32'h100);
    wr(4'h0, 32'h3);
    feed();
    bad_at = -1;
    bus_addr = 4'hC;
    for (int i = 1; i <= M + 2; i++) begin
      @(negedge clk);
      if (rst_req !== (i == M) && bad_at < 0) bad_at = i;
      if (i == 3) begin rd(4'hC, v); check("R4 before first tick", v, 32'h100); end
      if (i == 9) begin rd(4'hC, v); check("R4 two ticks", v, 32'hFE); end
      if (i == M) begin
        rd(4'hC, v); check("R7 reload after zero", v, 32'h100);
        rd(4'h0, v); check("R10 flag set", v, 32'h7);
        bus_addr = 4'hC;
      end
    end
    check("R7 request cycle (first mismatch index)", bad_at, -1);
    wr(4'h0, 32'h0);
    rd(4'h0, v); check("R10/R6 flag cleared bits locked", v, 32'h3);
    wr(4'h0, 32'h4);
    rd(4'h0, v); check("R10 write 1 no set", v, 32'h3);
  endtask

  task automatic t_quiet_expiry();
    logic [31:0] v;
    int seen;
    localparam int M = 4 * 256;
    apply_reset();
    wr(4'h0, 32'h1);
    feed();
    seen = 0;
    bus_addr = 4'hC;
    for (int i = 1; i <= M + 2; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
      if (i == M - 1) begin rd(4'hC, v); check("R7 count at zero", v, 32'h0); end
      if (i == M)     begin rd(4'hC, v); check("R7 reload quiet", v, 32'hFF); end
    end
    check("R11 no request without permit", seen, 0);
    rd(4'h0, v); check("R10 no flag without permit", v, 32'h1);
  endtask

  task automatic t_bad_key();
    logic [31:0] v;
    apply_reset();
    wr(4'h0, 32'h3);
    feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h56);
    check("R8 bad second word", {31'b0, rst_req}, 32'h1);
    @(negedge clk);
    check("R8 one cycle", {31'b0, rst_req}, 32'h0);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'hAA);
    check("R8 repeated first word", {31'b0, rst_req}, 32'h1);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h155);
    check("R3/R8 full word compare", {31'b0, rst_req}, 32'h1);
    rd(4'h0, v); check("R10 no flag on bad key", v, 32'h3);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    apply_reset();
    wr(4'h0, 32'h3);
    feed();
    wr(4'h8, 32'hAA);
    wr(4'h4, 32'h400);
    check("R9 abort request", {31'b0, rst_req}, 32'h1);
    @(negedge clk);
    check("R9 one cycle", {31'b0, rst_req}, 32'h0);
    rd(4'h4, v); check("R9 aborting write kept", v, 32'h400);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_reload_clamp();
    t_unarmed();
    t_expiry();
    t_quiet_expiry();
    t_bad_key();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule